// File: doc/BRIEF.md
# PCI Function Event Queue Controller

This block sits beside a PCI host bridge that serves a fixed number of device slots. It keeps a first-in first-out queue of function events and a small per-slot table holding a live bit and a configured bit. Producers add events: error reports come straight from a port, and availability events come from an internal sequencer. On a plug request the sequencer brings a slot up and queues two events. On an unplug request it queues one or two events and takes the slot down. A consumer pops one event at a time into a flat response record. Each accepted push raises a one-cycle channel-report request, and the have-event output tells the consumer whether anything is waiting.

Configure and deconfigure commands name a function by its identifier. A slot's identifier equals its slot number, and its handle is the slot number with bit 31 set. A command gets a two-bit response code one cycle after it is presented. The sequencer has five states. ST_IDLE accepts work. ST_PLUG_STBY queues the reserved-to-standby event and then moves to ST_PLUG_CFG. ST_PLUG_CFG queues the to-configured event and then returns to ST_IDLE. ST_UNPL_CFG queues the configured-to-standby event, clears the configured bit and moves to ST_UNPL_RSV. ST_UNPL_RSV queues the standby-to-reserved event, clears the live bit and returns to ST_IDLE. From ST_IDLE, a plug goes to ST_PLUG_STBY. An unplug goes to ST_UNPL_CFG when the slot is configured, and otherwise to ST_UNPL_RSV.

When several requests arrive together in ST_IDLE, a plug wins over an unplug, and an unplug wins over a command. An error push is always taken in ST_IDLE, even in the same cycle as one of these.

Top module: `fn_event_ctrl`

## Requirements
- R1: After reset, have_event, overflow, busy, pop_done, rsp_valid and crw_req are all 0.
- R2: have_event is 1 exactly when the queue holds at least one event.
- R3: A pop_req on a non-empty queue gives, one cycle later, a one-cycle pop_done with pop_status 0, pop_nt 2 and the cc of the oldest event, which then leaves the queue. For cc 1 (error) the outputs pop_fid, pop_fh, pop_qual, pop_addr and pop_pec carry the pushed values. For cc 2 (availability) only pop_fid, pop_fh and pop_pec are copied, and pop_addr and pop_qual read 0. Events come out in the order they were pushed.
- R4: A pop_req on an empty queue gives pop_done with pop_status 1 and leaves pop_nt, pop_cc and every field output unchanged.
- R5: A plug of slot s marks the slot live and configured. It then queues two cc-2 events with fid s and fh s|0x8000_0000: first pec 0x0301 (reserved to standby), then pec 0x0302 (to configured).
- R6: An unplug of slot s queues pec 0x0303 (configured to standby) only if the slot is configured. It then always queues pec 0x0304 (standby to reserved), using the slot's fid and fh from before the unplug, and leaves the slot no longer live.
- R7: A command (cfg_on 1 to configure, 0 to deconfigure) aimed at a live slot already in the requested state answers rsp_code 2'b01 (no action) and changes nothing. Otherwise it toggles the configured bit and answers 2'b00 (normal). rsp_valid pulses one cycle after cfg_req.
- R8: A command whose fid matches no live slot, including any fid at or above the slot count, answers 2'b10 (not recognised).
- R9: The queue holds QDEPTH events. A push into a full queue is dropped and sets overflow, which stays 1 until reset.
- R10: crw_req pulses for one cycle, one cycle after every accepted push, and a dropped push gives no pulse.
- R11: busy is 1 outside ST_IDLE. Plug, unplug, error and command requests presented while busy is 1 are ignored. An error push taken in the same cycle as a plug is queued ahead of the plug's two events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_push | input | 1 | Queue an error event (taken only while idle) |
| err_fh | input | 32 | Error event function handle |
| err_fid | input | 32 | Error event function identifier |
| err_addr | input | 64 | Error event fault address |
| err_qual | input | 32 | Error event qualifier word |
| err_pec | input | 16 | Error event code |
| plug_req | input | 1 | Plug request |
| plug_slot | input | SLOT_W | Slot to plug |
| unplug_req | input | 1 | Unplug request |
| unplug_slot | input | SLOT_W | Slot to unplug |
| cfg_req | input | 1 | Configure or deconfigure command |
| cfg_on | input | 1 | 1 configure, 0 deconfigure |
| cfg_fid | input | 32 | Target function identifier |
| rsp_valid | output | 1 | Command response strobe |
| rsp_code | output | 2 | 00 normal, 01 no action, 10 not recognised |
| busy | output | 1 | Sequencer is outside ST_IDLE |
| pop_req | input | 1 | Pop the oldest event |
| pop_done | output | 1 | Pop result valid |
| pop_status | output | 1 | 0 event returned, 1 queue was empty |
| pop_nt | output | 8 | Notification type |
| pop_cc | output | 2 | Event format code |
| pop_fid | output | 32 | Function identifier |
| pop_fh | output | 32 | Function handle |
| pop_qual | output | 32 | Qualifier word |
| pop_addr | output | 64 | Fault address |
| pop_pec | output | 16 | Event code |
| have_event | output | 1 | Queue non-empty |
| overflow | output | 1 | Sticky dropped-push flag |
| crw_req | output | 1 | Channel-report request pulse |

## Verification
The bench builds the block with four slots and a queue depth of four. Four slots let every slot be plugged and unplugged, and let command sweeps run over every identifier from 0 up past the slot count, so both the live and the unrecognised answers are reached. A depth of four makes the full queue, the dropped push and the sticky overflow flag reachable within a few cycles. With that depth, a wrap of the queue pointers occurs inside the plug sequences.

// File: rtl/fn_evq_pkg.sv
package fn_evq_pkg;

    localparam int FID_W       = 32;
    localparam int FH_W        = 32;
    localparam int FADDR_W     = 64;
    localparam int QUAL_W      = 32;
    localparam int PEC_W       = 16;
    localparam int FH_VIRT_BIT = 31;

    localparam logic [1:0] CC_ERROR = 2'd1;
    localparam logic [1:0] CC_AVAIL = 2'd2;

    localparam logic [PEC_W-1:0] PEC_RSV_TO_STBY = 16'h0301;
    localparam logic [PEC_W-1:0] PEC_TO_CFG      = 16'h0302;
    localparam logic [PEC_W-1:0] PEC_CFG_TO_STBY = 16'h0303;
    localparam logic [PEC_W-1:0] PEC_STBY_TO_RSV = 16'h0304;

    localparam logic [1:0] RSP_NORMAL  = 2'b00;
    localparam logic [1:0] RSP_NOACT   = 2'b01;
    localparam logic [1:0] RSP_UNKNOWN = 2'b10;

    typedef struct packed {
        logic [1:0]         cc;
        logic [PEC_W-1:0]   pec;
        logic [FH_W-1:0]    fh;
        logic [FID_W-1:0]   fid;
        logic [FADDR_W-1:0] faddr;
        logic [QUAL_W-1:0]  qual;
    } evt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLUG_STBY,
        ST_PLUG_CFG,
        ST_UNPL_CFG,
        ST_UNPL_RSV
    } seq_state_e;

    typedef enum logic [1:0] {
        TOP_NONE,
        TOP_PLUG,
        TOP_CLR_CFG,
        TOP_CLR_LIVE
    } tbl_op_e;

endpackage

// File: rtl/fn_evq_fifo.sv
module fn_evq_fifo
    import fn_evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  evt_t din,
    input  logic pop,
    output evt_t dout,
    output logic empty,
    output logic full,
    output logic push_ok,
    output logic overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    evt_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             rd_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign rd_ok   = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= next_ptr(wr_ptr);
            if (rd_ok)   rd_ptr <= next_ptr(rd_ptr);
            if (push_ok && !rd_ok)      count <= count + 1'b1;
            else if (rd_ok && !push_ok) count <= count - 1'b1;
            if (push && full) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/fn_slot_table.sv
module fn_slot_table
    import fn_evq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  tbl_op_e              op,
    input  logic [SLOT_W-1:0]    op_slot,
    input  logic                 tog_en,
    input  logic [SLOT_W-1:0]    tog_slot,
    output logic [NUM_SLOTS-1:0] live,
    output logic [NUM_SLOTS-1:0] cfgd
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic hit_op, hit_tog;
        assign hit_op  = (op_slot  == SLOT_W'(g));
        assign hit_tog = tog_en && (tog_slot == SLOT_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live[g] <= 1'b0;
                cfgd[g] <= 1'b0;
            end else if (hit_op && op == TOP_PLUG) begin
                live[g] <= 1'b1;
                cfgd[g] <= 1'b1;
            end else if (hit_op && op == TOP_CLR_CFG) begin
                cfgd[g] <= 1'b0;
            end else if (hit_op && op == TOP_CLR_LIVE) begin
                live[g] <= 1'b0;
            end else if (hit_tog) begin
                cfgd[g] <= !cfgd[g];
            end
        end
    end

endmodule

// File: rtl/fn_evq_seq.sv
module fn_evq_seq
    import fn_evq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 err_push,
    input  logic [FH_W-1:0]      err_fh,
    input  logic [FID_W-1:0]     err_fid,
    input  logic [FADDR_W-1:0]   err_addr,
    input  logic [QUAL_W-1:0]    err_qual,
    input  logic [PEC_W-1:0]     err_pec,
    input  logic                 plug_req,
    input  logic [SLOT_W-1:0]    plug_slot,
    input  logic                 unplug_req,
    input  logic [SLOT_W-1:0]    unplug_slot,
    input  logic                 cfg_req,
    input  logic                 cfg_on,
    input  logic [FID_W-1:0]     cfg_fid,
    input  logic [NUM_SLOTS-1:0] live,
    input  logic [NUM_SLOTS-1:0] cfgd,
    output logic                 push,
    output evt_t                 push_evt,
    output tbl_op_e              op,
    output logic [SLOT_W-1:0]    op_slot,
    output logic                 tog_en,
    output logic [SLOT_W-1:0]    tog_slot,
    output logic                 busy,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_code
);
    seq_state_e        state, state_nx;
    logic [SLOT_W-1:0] cur_slot, cur_slot_nx;
    logic              cfg_take, cfg_hit, cfg_same;
    logic [SLOT_W-1:0] cfg_slot;
    logic [1:0]        rsp_code_nx;
    evt_t              avail_evt;

    assign cfg_slot = cfg_fid[SLOT_W-1:0];
    assign cfg_hit  = (cfg_fid < FID_W'(NUM_SLOTS)) && live[cfg_slot];
    assign cfg_same = (cfg_on == cfgd[cfg_slot]);
    assign cfg_take = (state == ST_IDLE) && cfg_req && !plug_req && !unplug_req;
    assign busy     = (state != ST_IDLE);

    always_comb begin
        avail_evt       = '0;
        avail_evt.cc    = CC_AVAIL;
        avail_evt.fid   = live[cur_slot] ? FID_W'(cur_slot) : '0;
        avail_evt.fh    = live[cur_slot] ?
                          (FH_W'(cur_slot) | (FH_W'(1) << FH_VIRT_BIT)) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_slot  <= '0;
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_NORMAL;
        end else begin
            state     <= state_nx;
            cur_slot  <= cur_slot_nx;
            rsp_valid <= cfg_take;
            if (cfg_take) rsp_code <= rsp_code_nx;
        end
    end

    always_comb begin
        state_nx    = state;
        cur_slot_nx = cur_slot;
        push        = 1'b0;
        push_evt    = avail_evt;
        op          = TOP_NONE;
        op_slot     = cur_slot;
        tog_en      = 1'b0;
        tog_slot    = cfg_slot;
        rsp_code_nx = RSP_UNKNOWN;
        unique case (state)
            ST_IDLE: begin
                if (err_push) begin
                    push           = 1'b1;
                    push_evt.cc    = CC_ERROR;
                    push_evt.pec   = err_pec;
                    push_evt.fh    = err_fh;
                    push_evt.fid   = err_fid;
                    push_evt.faddr = err_addr;
                    push_evt.qual  = err_qual;
                end
                if (plug_req) begin
                    op          = TOP_PLUG;
                    op_slot     = plug_slot;
                    cur_slot_nx = plug_slot;
                    state_nx    = ST_PLUG_STBY;
                end else if (unplug_req) begin
                    cur_slot_nx = unplug_slot;
                    state_nx    = cfgd[unplug_slot] ? ST_UNPL_CFG : ST_UNPL_RSV;
                end else if (cfg_req) begin
                    if (!cfg_hit) begin
                        rsp_code_nx = RSP_UNKNOWN;
                    end else if (cfg_same) begin
                        rsp_code_nx = RSP_NOACT;
                    end else begin
                        rsp_code_nx = RSP_NORMAL;
                        tog_en      = 1'b1;
                    end
                end
            end
            ST_PLUG_STBY: begin
                push         = 1'b1;
                push_evt.pec = PEC_RSV_TO_STBY;
                state_nx     = ST_PLUG_CFG;
            end
            ST_PLUG_CFG: begin
                push         = 1'b1;
                push_evt.pec = PEC_TO_CFG;
                state_nx     = ST_IDLE;
            end
            ST_UNPL_CFG: begin
                push         = 1'b1;
                push_evt.pec = PEC_CFG_TO_STBY;
                op           = TOP_CLR_CFG;
                state_nx     = ST_UNPL_RSV;
            end
            ST_UNPL_RSV: begin
                push         = 1'b1;
                push_evt.pec = PEC_STBY_TO_RSV;
                op           = TOP_CLR_LIVE;
                state_nx     = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/fn_event_ctrl.sv
module fn_event_ctrl
    import fn_evq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int QDEPTH    = 16,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_push,
    input  logic [31:0]        err_fh,
    input  logic [31:0]        err_fid,
    input  logic [63:0]        err_addr,
    input  logic [31:0]        err_qual,
    input  logic [15:0]        err_pec,
    input  logic               plug_req,
    input  logic [SLOT_W-1:0]  plug_slot,
    input  logic               unplug_req,
    input  logic [SLOT_W-1:0]  unplug_slot,
    input  logic               cfg_req,
    input  logic               cfg_on,
    input  logic [31:0]        cfg_fid,
    output logic               rsp_valid,
    output logic [1:0]         rsp_code,
    output logic               busy,
    input  logic               pop_req,
    output logic               pop_done,
    output logic               pop_status,
    output logic [7:0]         pop_nt,
    output logic [1:0]         pop_cc,
    output logic [31:0]        pop_fid,
    output logic [31:0]        pop_fh,
    output logic [31:0]        pop_qual,
    output logic [63:0]        pop_addr,
    output logic [15:0]        pop_pec,
    output logic               have_event,
    output logic               overflow,
    output logic               crw_req
);
    logic                 push, push_ok, q_empty, q_full;
    evt_t                 push_evt, head;
    tbl_op_e              op;
    logic [SLOT_W-1:0]    op_slot, tog_slot;
    logic                 tog_en;
    logic [NUM_SLOTS-1:0] live, cfgd;

    fn_evq_seq #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .err_push(err_push), .err_fh(err_fh), .err_fid(err_fid),
        .err_addr(err_addr), .err_qual(err_qual), .err_pec(err_pec),
        .plug_req(plug_req), .plug_slot(plug_slot),
        .unplug_req(unplug_req), .unplug_slot(unplug_slot),
        .cfg_req(cfg_req), .cfg_on(cfg_on), .cfg_fid(cfg_fid),
        .live(live), .cfgd(cfgd),
        .push(push), .push_evt(push_evt),
        .op(op), .op_slot(op_slot), .tog_en(tog_en), .tog_slot(tog_slot),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_code(rsp_code)
    );

    fn_slot_table #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .op(op), .op_slot(op_slot),
        .tog_en(tog_en), .tog_slot(tog_slot), .live(live), .cfgd(cfgd)
    );

    fn_evq_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(push_evt),
        .pop(pop_req), .dout(head), .empty(q_empty), .full(q_full),
        .push_ok(push_ok), .overflow(overflow)
    );

    assign have_event = !q_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_done   <= 1'b0;
            pop_status <= 1'b0;
            pop_nt     <= '0;
            pop_cc     <= '0;
            pop_fid    <= '0;
            pop_fh     <= '0;
            pop_qual   <= '0;
            pop_addr   <= '0;
            pop_pec    <= '0;
            crw_req    <= 1'b0;
        end else begin
            crw_req  <= push_ok;
            pop_done <= pop_req;
            if (pop_req) begin
                pop_status <= q_empty;
                if (!q_empty) begin
                    pop_nt  <= 8'd2;
                    pop_cc  <= head.cc;
                    pop_fid <= head.fid;
                    pop_fh  <= head.fh;
                    pop_pec <= head.pec;
                    if (head.cc == CC_ERROR) begin
                        pop_qual <= head.qual;
                        pop_addr <= head.faddr;
                    end else begin
                        pop_qual <= '0;
                        pop_addr <= '0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fn_event_ctrl_chk.sv
module fn_event_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       plug_req,
    input logic       busy,
    input logic       rsp_valid,
    input logic [1:0] rsp_code,
    input logic       pop_done,
    input logic       pop_status,
    input logic [1:0] pop_cc,
    input logic [31:0] pop_qual,
    input logic [63:0] pop_addr,
    input logic       have_event,
    input logic       overflow,
    input logic       crw_req
);
    // R2
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_done && pop_status) |-> !$past(have_event));

    // R2
    full_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_done && !pop_status) |-> $past(have_event));

    // R3
    avail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_done && !pop_status && pop_cc == 2'd2) |-> (pop_addr == '0 && pop_qual == '0));

    // R7
    rsp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code != 2'b11));

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R10
    crw_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crw_req |-> have_event);

    // R11
    plug_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_req && !busy) |=> busy);

endmodule

bind fn_event_ctrl fn_event_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .plug_req(plug_req), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .pop_done(pop_done),
    .pop_status(pop_status), .pop_cc(pop_cc), .pop_qual(pop_qual),
    .pop_addr(pop_addr), .have_event(have_event), .overflow(overflow),
    .crw_req(crw_req)
);

// File: tb/fn_event_ctrl_tb.sv
module fn_event_ctrl_tb;
    localparam int NS     = 4;
    localparam int QD     = 4;
    localparam int SW     = 2;
    localparam logic [31:0] VBIT = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_push = 0, plug_req = 0, unplug_req = 0, cfg_req = 0, cfg_on = 0, pop_req = 0;
    logic [31:0] err_fh = 0, err_fid = 0, err_qual = 0, cfg_fid = 0;
    logic [63:0] err_addr = 0;
    logic [15:0] err_pec = 0;
    logic [SW-1:0] plug_slot = 0, unplug_slot = 0;
    logic rsp_valid, busy, pop_done, pop_status, have_event, overflow, crw_req;
    logic [1:0] rsp_code, pop_cc;
    logic [7:0] pop_nt;
    logic [31:0] pop_fid, pop_fh, pop_qual;
    logic [63:0] pop_addr;
    logic [15:0] pop_pec;

    int checks = 0, fails = 0, crw_cnt = 0;
    bit cfg_model [NS];

    always #2 clk = ~clk;

    fn_event_ctrl #(.NUM_SLOTS(NS), .QDEPTH(QD)) u_dut (
        .clk(clk), .rst_n(rst_n), .err_push(err_push), .err_fh(err_fh),
        .err_fid(err_fid), .err_addr(err_addr), .err_qual(err_qual), .err_pec(err_pec),
        .plug_req(plug_req), .plug_slot(plug_slot), .unplug_req(unplug_req),
        .unplug_slot(unplug_slot), .cfg_req(cfg_req), .cfg_on(cfg_on), .cfg_fid(cfg_fid),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .busy(busy), .pop_req(pop_req),
        .pop_done(pop_done), .pop_status(pop_status), .pop_nt(pop_nt), .pop_cc(pop_cc),
        .pop_fid(pop_fid), .pop_fh(pop_fh), .pop_qual(pop_qual), .pop_addr(pop_addr),
        .pop_pec(pop_pec), .have_event(have_event), .overflow(overflow), .crw_req(crw_req)
    );

    always @(negedge clk) if (rst_n && crw_req) crw_cnt++;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pop_expect(input string req, input logic [1:0] cc, input logic [15:0] pec,
                              input logic [31:0] fid, input logic [31:0] fh,
                              input logic [63:0] addr, input logic [31:0] qual);
        @(negedge clk) pop_req = 1;
        @(negedge clk) pop_req = 0;
        chk(req, "pop_done", pop_done, 1);
        chk(req, "status", pop_status, 0);
        chk(req, "nt", pop_nt, 2);
        chk(req, "cc", pop_cc, cc);
        chk(req, "pec", pop_pec, pec);
        chk(req, "fid", pop_fid, fid);
        chk(req, "fh", pop_fh, fh);
        chk(req, "addr", pop_addr, addr);
        chk(req, "qual", pop_qual, qual);
    endtask

    task automatic pop_empty(input string req);
        logic [31:0] f0, h0; logic [15:0] p0; logic [1:0] c0;
        f0 = pop_fid; h0 = pop_fh; p0 = pop_pec; c0 = pop_cc;
        @(negedge clk) pop_req = 1;
        @(negedge clk) pop_req = 0;
        chk(req, "empty pop_done", pop_done, 1);
        chk(req, "empty status", pop_status, 1);
        chk(req, "empty fid held", pop_fid, f0);
        chk(req, "empty fh held", pop_fh, h0);
        chk(req, "empty pec held", pop_pec, p0);
        chk(req, "empty cc held", pop_cc, c0);
    endtask

    task automatic plug(input int s);
        @(negedge clk) plug_req = 1; plug_slot = SW'(s);
        @(negedge clk) plug_req = 0;
        idle(3);
        cfg_model[s] = 1;
    endtask

    task automatic unplug(input int s);
        @(negedge clk) unplug_req = 1; unplug_slot = SW'(s);
        @(negedge clk) unplug_req = 0;
        idle(3);
    endtask

    task automatic cfg(input string req, input logic [31:0] fid, input bit on, input logic [1:0] exp);
        @(negedge clk) cfg_req = 1; cfg_fid = fid; cfg_on = on;
        @(negedge clk) cfg_req = 0;
        chk(req, "rsp_valid", rsp_valid, 1);
        chk(req, "rsp_code", rsp_code, exp);
    endtask

    task automatic err(input logic [31:0] fid, input logic [31:0] fh, input logic [63:0] a,
                       input logic [31:0] q, input logic [15:0] p);
        err_push = 1; err_fid = fid; err_fh = fh; err_addr = a; err_qual = q; err_pec = p;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c0;
        idle(3);
        // R1 reset values
        chk("R1", "have_event", have_event, 0);
        chk("R1", "overflow", overflow, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "pop_done", pop_done, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "crw_req", crw_req, 0);
        @(negedge clk) rst_n = 1;
        idle(1);

        // R4 empty pop
        pop_empty("R4");

        // R8 nothing live yet
        for (int f = 0; f < 6; f++) cfg("R8", 32'(f), f[0], 2'b10);

        // R5 plug every slot
        for (int s = 0; s < NS; s++) begin
            c0 = crw_cnt;
            plug(s);
            chk("R2", "have_event after plug", have_event, 1);
            chk("R10", "crw pulses per plug", 64'(crw_cnt - c0), 2);
            pop_expect("R5", 2, 16'h0301, 32'(s), 32'(s) | VBIT, 0, 0);
            pop_expect("R5", 2, 16'h0302, 32'(s), 32'(s) | VBIT, 0, 0);
            chk("R2", "have_event drained", have_event, 0);
        end

        // R7 configure sweep
        for (int s = 0; s < NS; s++) begin
            for (int k = 0; k < 4; k++) begin
                bit on;
                on = k[0];
                cfg("R7", 32'(s), on, (on == cfg_model[s]) ? 2'b01 : 2'b00);
                cfg_model[s] = on;
            end
            if (s % 2 == 1) begin
                cfg("R7", 32'(s), 0, 2'b00);
                cfg_model[s] = 0;
            end
        end
        for (int f = NS; f < NS + 3; f++) cfg("R8", 32'(f), 1, 2'b10);
        cfg("R8", 32'hFFFF_FFFF, 0, 2'b10);

        // R3 error event
        @(negedge clk) err(32'h55, 32'h8000_0002, 64'h1234_5678_9ABC_DEF0, 32'hA5A5_0001, 16'h0010);
        @(negedge clk) err_push = 0;
        pop_expect("R3", 1, 16'h0010, 32'h55, 32'h8000_0002, 64'h1234_5678_9ABC_DEF0, 32'hA5A5_0001);

        // R6 unplug of deconfigured slot 1: one event
        unplug(1);
        pop_expect("R6", 2, 16'h0304, 32'd1, 32'd1 | VBIT, 0, 0);
        pop_empty("R6");
        cfg("R6", 32'd1, 1, 2'b10);

        // R6 unplug of configured slot 0: two events
        unplug(0);
        pop_expect("R6", 2, 16'h0303, 32'd0, VBIT, 0, 0);
        pop_expect("R6", 2, 16'h0304, 32'd0, VBIT, 0, 0);
        cfg("R6", 32'd0, 0, 2'b10);

        // R9 overflow with depth 4
        c0 = crw_cnt;
        for (int i = 0; i < QD + 1; i++) begin
            @(negedge clk) err(32'd9, 32'd9, 64'(i), 32'(i), 16'h0020);
        end
        @(negedge clk) err_push = 0;
        idle(1);
        chk("R9", "overflow", overflow, 1);
        chk("R10", "crw pulses on fill", 64'(crw_cnt - c0), QD);
        for (int i = 0; i < QD; i++)
            pop_expect("R3", 1, 16'h0020, 32'd9, 32'd9, 64'(i), 32'(i));
        pop_empty("R9");
        chk("R9", "overflow sticky", overflow, 1);

        // R11 requests while busy are ignored
        @(negedge clk) plug_req = 1; plug_slot = 2'd2;
        @(negedge clk) plug_req = 0; cfg_req = 1; cfg_fid = 32'd2; cfg_on = 0;
        unplug_req = 1; unplug_slot = 2'd2;
        chk("R11", "busy", busy, 1);
        @(negedge clk) cfg_req = 0; unplug_req = 0;
        chk("R11", "no rsp while busy", rsp_valid, 0);
        idle(3);
        pop_expect("R11", 2, 16'h0301, 32'd2, 32'd2 | VBIT, 0, 0);
        pop_expect("R11", 2, 16'h0302, 32'd2, 32'd2 | VBIT, 0, 0);
        pop_empty("R11");
        cfg("R11", 32'd2, 1, 2'b01);

        // R11 error alongside plug is queued first
        @(negedge clk) plug_req = 1; plug_slot = 2'd3;
        err(32'h77, 32'h66, 64'hABC, 32'h3, 16'h0040);
        @(negedge clk) plug_req = 0; err_push = 0;
        idle(3);
        pop_expect("R11", 1, 16'h0040, 32'h77, 32'h66, 64'hABC, 32'h3);
        pop_expect("R11", 2, 16'h0301, 32'd3, 32'd3 | VBIT, 0, 0);
        pop_expect("R11", 2, 16'h0302, 32'd3, 32'd3 | VBIT, 0, 0);
        chk("R2", "have_event final", have_event, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule